// File: doc/BRIEF.md
# Clause-22 Management Responder (PHY Side)

This block sits on the PHY side of a two-wire station management link that a host drives by bit-banging. It watches three host-side signals (management clock, host data-out and host output-enable), brings them into the system clock domain, and acts on each rising edge of the management clock. A frame starts once a long run of one bits has been seen. The responder then decodes a 16-bit header that selects a read or a write of one of 32 sixteen-bit registers. On a read, it returns the register value serially on its data-in output. On a write, it captures the 16 data bits that follow and stores them.

The PHY address field is decoded but never compared, so every address is answered. Registers 2 and 3 carry a fixed identifier and cannot be written. A malformed header drops the responder back to idle without side effects. Inside the block, `mgmt_frame` holds a three-state machine:

- ST_IDLE leaves for ST_READ on a valid read header, or for ST_WRITE on a valid write header. Both transitions happen at the decode point.
- ST_READ returns to ST_IDLE after the sixteenth data edge. It shifts one bit out per edge.
- ST_WRITE returns to ST_IDLE after the sixteenth data edge, where it commits the word.

A new decode point can also move either active state directly to the state the newly decoded header selects.

Top module: `mgmt_phy_responder`

## Requirements
- R1: After reset, register 2 holds 0x0022 and register 3 holds 0x161A. The other 30 registers hold zero, and the data-in output is low.
- R2: The bit taken on a rising management-clock edge is host data-out AND host output-enable. A bit clocked while the enable is low counts as zero even if data-out is high.
- R3: Only rising management-clock edges shift bits. A frame is recognised only after 32 consecutive sampled ones. Thirty-one ones followed by a well-formed header cause no register change and no response.
- R4: The 16 bits after synchronisation are decoded in transmission order: start (2 bits), opcode (2), PHY address (5, MSB first), register address (5, MSB first), turnaround (2). A read drives the addressed register MSB first on the data-in output, one bit after each of the next 16 rising edges.
- R5: A write is accepted only when start is 01, opcode is 01 and turnaround is 10.
- R6: A read is accepted when start is 01, opcode is 10 and the second turnaround bit is 0. The first turnaround bit may be 0 or 1.
- R7: Any other start, opcode or turnaround combination returns the responder to idle. In that case no register changes and the data-in output keeps its value.
- R8: After an accepted write header, the next 16 bits (MSB first) are stored into the addressed register on the 16th of those edges. A later read returns exactly that word.
- R9: The PHY address is not compared. Frames carrying any PHY address value act on the same register set.
- R10: Writes addressed to registers 2 and 3 leave their identifier values unchanged.
- R11: The data-in output holds its last driven value whenever no read data is being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mgt_clk_i | input | 1 | Management clock from the host, asynchronous |
| mgt_dout_i | input | 1 | Host data-out line |
| mgt_oe_i | input | 1 | Host output-enable qualifying data-out |
| mgt_din_o | output | 1 | Serial read data returned to the host |

## Verification
The hardest case to provoke is a frame that must be rejected: a preamble one bit short, or a bad header code. In these cases the only visible evidence is that nothing happens, which cannot be seen while the data-in line already sits at the value a response would begin with. The bench first reads a register whose last bit is 1, which parks the output high. It then sends a few enable-low zero bits so that no stray run of ones carries over. Only then does it send a 31-one preamble or a corrupted header, aimed at the identifier register whose first bit is 0. A spurious response would therefore pull the line low within the first data edge.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } mgmt_state_e;

    // header field positions within the low 16 bits of the shift window
    localparam int F_START_LSB = 14;
    localparam int F_OP_LSB    = 12;
    localparam int F_PHY_LSB   = 7;
    localparam int F_REG_LSB   = 2;
    localparam int F_TA_LSB    = 0;

    localparam logic [1:0] START_CODE = 2'b01;
    localparam logic [1:0] OP_WRITE   = 2'b01;
    localparam logic [1:0] OP_READ    = 2'b10;
    localparam logic [1:0] TA_WRITE   = 2'b10;

endpackage

// File: rtl/mgmt_sync.sv
module mgmt_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/mgmt_sampler.sv
module mgmt_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc_i,
    input  logic dout_i,
    input  logic oe_i,
    output logic rise_o,
    output logic bit_o
);

    localparam int LINES = 3;

    logic [LINES-1:0] raw_lines;
    logic [LINES-1:0] synced;
    logic             mdc_prev_q;

    assign raw_lines = {mdc_i, dout_i, oe_i};

    mgmt_sync #(
        .STAGES(SYNC_STAGES),
        .WIDTH (LINES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(raw_lines),
        .sync_o (synced)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdc_prev_q <= 1'b0;
        end else begin
            mdc_prev_q <= synced[2];
        end
    end

    // one-cycle strobe on a low-to-high management clock transition
    assign rise_o = synced[2] & ~mdc_prev_q;
    // a released driver contributes a zero
    assign bit_o  = synced[1] & synced[0];

endmodule

// File: rtl/mgmt_frame.sv
module mgmt_frame
    import mgmt_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 5,
    localparam int FRAME_W = 2 * DATA_W,
    localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic              bit_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              din_o,
    output mgmt_state_e       state_o,
    output logic [CNT_W-1:0]  cnt_o
);

    // only FRAME_W-1 history bits are kept: the oldest falls out on the shift
    logic [FRAME_W-2:0] shift_q;
    logic [FRAME_W-1:0] shift_nxt;
    logic [CNT_W-1:0]   cnt_q, cnt_eff, cnt_nxt;
    logic [ADDR_W-1:0]  reg_addr_q;
    logic [DATA_W-1:0]  out_q;
    logic               din_q;

    mgmt_state_e state_q, state_nxt, st_mid, dec_state;

    logic [1:0] f_start, f_op, f_ta;
    logic       sync_hit, at_decode, in_serial, at_end;

    assign shift_nxt = {shift_q, bit_i};
    assign sync_hit  = &shift_nxt;

    assign f_start   = shift_nxt[F_START_LSB +: 2];
    assign f_op      = shift_nxt[F_OP_LSB +: 2];
    assign f_ta      = shift_nxt[F_TA_LSB +: 2];
    assign rd_addr_o = shift_nxt[F_REG_LSB +: ADDR_W];

    assign cnt_eff   = sync_hit ? CNT_W'(FRAME_W) : cnt_q;
    assign at_decode = rise_i && (cnt_eff == CNT_W'(DATA_W));

    always_comb begin
        dec_state = ST_IDLE;
        if (f_start == START_CODE && f_op == OP_WRITE && f_ta == TA_WRITE) begin
            dec_state = ST_WRITE;
        end else if (f_start == START_CODE && f_op == OP_READ && !f_ta[0]) begin
            dec_state = ST_READ;
        end
    end

    // next state
    always_comb begin
        st_mid = at_decode ? dec_state : state_q;
        state_nxt = st_mid;
        if (rise_i) begin
            unique case (st_mid)
                ST_IDLE:  state_nxt = ST_IDLE;
                ST_READ:  if (cnt_eff == '0) state_nxt = ST_IDLE;
                ST_WRITE: if (cnt_eff == '0) state_nxt = ST_IDLE;
                default:  state_nxt = ST_IDLE;
            endcase
        end
    end

    assign in_serial = rise_i && (cnt_eff < CNT_W'(DATA_W)) && (st_mid == ST_READ);
    assign at_end    = rise_i && (cnt_eff == '0) && (st_mid != ST_IDLE);

    // counter saturates at zero so the decode point cannot recur without a new sync
    assign cnt_nxt = !rise_i ? cnt_q :
                     (cnt_eff == '0) ? '0 : cnt_eff - CNT_W'(1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q    <= '0;
            cnt_q      <= '0;
            reg_addr_q <= '0;
        end else if (rise_i) begin
            shift_q <= shift_nxt[FRAME_W-2:0];
            cnt_q   <= cnt_nxt;
            if (at_decode && dec_state != ST_IDLE) begin
                reg_addr_q <= rd_addr_o;
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
            din_q <= 1'b0;
        end else if (at_decode && dec_state == ST_READ) begin
            out_q <= rd_data_i;
        end else if (in_serial) begin
            din_q <= out_q[DATA_W-1];
            out_q <= {out_q[DATA_W-2:0], 1'b0};
        end
    end

    assign wr_en_o   = at_end && (st_mid == ST_WRITE);
    assign wr_addr_o = reg_addr_q;
    assign wr_data_o = shift_nxt[DATA_W-1:0];
    assign din_o     = din_q;
    assign state_o   = state_q;
    assign cnt_o     = cnt_q;

endmodule

// File: rtl/mgmt_regfile.sv
module mgmt_regfile #(
    parameter int              DATA_W    = 16,
    parameter int              ADDR_W    = 5,
    parameter int              ID_HI_IDX = 2,
    parameter int              ID_LO_IDX = 3,
    parameter logic [DATA_W-1:0] ID_HI_VAL = 16'h0022,
    parameter logic [DATA_W-1:0] ID_LO_VAL = 16'h161A,
    localparam int DEPTH = 2 ** ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);

    logic [DEPTH-1:0][DATA_W-1:0] rd_bus;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_entry
            if (i == ID_HI_IDX) begin : g_id_hi
                assign rd_bus[i] = ID_HI_VAL;
            end else if (i == ID_LO_IDX) begin : g_id_lo
                assign rd_bus[i] = ID_LO_VAL;
            end else begin : g_rw
                logic [DATA_W-1:0] val_q;
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        val_q <= '0;
                    end else if (wr_en_i && wr_addr_i == ADDR_W'(i)) begin
                        val_q <= wr_data_i;
                    end
                end
                assign rd_bus[i] = val_q;
            end
        end
    endgenerate

    assign rd_data_o = rd_bus[rd_addr_i];

endmodule

// File: rtl/mgmt_phy_responder.sv
module mgmt_phy_responder
    import mgmt_pkg::*;
#(
    parameter int              SYNC_STAGES = 2,
    parameter int              DATA_W      = 16,
    parameter int              ADDR_W      = 5,
    parameter int              ID_HI_IDX   = 2,
    parameter int              ID_LO_IDX   = 3,
    parameter logic [15:0]     ID_HI_VAL   = 16'h0022,
    parameter logic [15:0]     ID_LO_VAL   = 16'h161A
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mgt_clk_i,
    input  logic mgt_dout_i,
    input  logic mgt_oe_i,
    output logic mgt_din_o
);

    localparam int CNT_W = $clog2(2 * DATA_W + 1);

    logic              mdc_rise;
    logic              mdc_bit;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    mgmt_state_e       fsm_state;
    logic [CNT_W-1:0]  bit_cnt;

    mgmt_sampler #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sampler (
        .clk   (clk),
        .rst_n (rst_n),
        .mdc_i (mgt_clk_i),
        .dout_i(mgt_dout_i),
        .oe_i  (mgt_oe_i),
        .rise_o(mdc_rise),
        .bit_o (mdc_bit)
    );

    mgmt_frame #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_i   (mdc_rise),
        .bit_i    (mdc_bit),
        .rd_data_i(rd_data),
        .rd_addr_o(rd_addr),
        .wr_en_o  (wr_en),
        .wr_addr_o(wr_addr),
        .wr_data_o(wr_data),
        .din_o    (mgt_din_o),
        .state_o  (fsm_state),
        .cnt_o    (bit_cnt)
    );

    mgmt_regfile #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .ID_HI_IDX(ID_HI_IDX),
        .ID_LO_IDX(ID_LO_IDX),
        .ID_HI_VAL(DATA_W'(ID_HI_VAL)),
        .ID_LO_VAL(DATA_W'(ID_LO_VAL))
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en),
        .wr_addr_i(wr_addr),
        .wr_data_i(wr_data),
        .rd_addr_i(rd_addr),
        .rd_data_o(rd_data)
    );

endmodule

// File: rtl/mgmt_phy_responder_chk.sv
module mgmt_phy_responder_chk
    import mgmt_pkg::*;
#(
    parameter int          DATA_W    = 16,
    parameter int          ADDR_W    = 5,
    parameter int          ID_HI_IDX = 2,
    parameter int          ID_LO_IDX = 3,
    parameter logic [15:0] ID_HI_VAL = 16'h0022,
    parameter logic [15:0] ID_LO_VAL = 16'h161A,
    localparam int CNT_W = $clog2(2 * DATA_W + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rise,
    input mgmt_state_e       state,
    input logic [CNT_W-1:0]  cnt,
    input logic              wr_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              din
);

    p_din_steady_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(din));

    p_state_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(state));

    p_cnt_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(cnt));

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(2 * DATA_W));

    p_commit_in_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (rise && state == ST_WRITE));

    p_read_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_READ) |-> (cnt == CNT_W'(DATA_W - 1)));

    p_id_hi_fixed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_W'(ID_HI_IDX)) |-> (rd_data == DATA_W'(ID_HI_VAL)));

    p_id_lo_fixed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_W'(ID_LO_IDX)) |-> (rd_data == DATA_W'(ID_LO_VAL)));

endmodule

bind mgmt_phy_responder mgmt_phy_responder_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .rise   (mdc_rise),
    .state  (fsm_state),
    .cnt    (bit_cnt),
    .wr_en  (wr_en),
    .rd_addr(rd_addr),
    .rd_data(rd_data),
    .din    (mgt_din_o)
);

// File: tb/mgmt_phy_responder_bench.sv
module mgmt_phy_responder_bench;

    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mgt_clk_r = 1'b0;
    logic mgt_dout_r = 1'b0;
    logic mgt_oe_r = 1'b0;
    logic mgt_din_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mgmt_phy_responder u_mgmt_phy_responder (
        .clk       (clk),
        .rst_n     (rst_n),
        .mgt_clk_i (mgt_clk_r),
        .mgt_dout_i(mgt_dout_r),
        .mgt_oe_i  (mgt_oe_r),
        .mgt_din_o (mgt_din_o)
    );

    task automatic check16(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
        end
    endtask

    task automatic send_bit(input logic b, input logic oe, output logic s);
        @(negedge clk);
        mgt_dout_r = b;
        mgt_oe_r   = oe;
        mgt_clk_r  = 1'b0;
        repeat (HALF) @(negedge clk);
        mgt_clk_r = 1'b1;
        repeat (HALF) @(negedge clk);
        s = mgt_din_o;
    endtask

    task automatic run_frame(input int pre_len, input logic [1:0] st, input logic [1:0] op,
                             input logic [4:0] phy, input logic [4:0] rg,
                             input logic [1:0] ta, input logic ta_oe,
                             input logic [15:0] data, input logic data_oe,
                             output logic [15:0] seen);
        logic s;
        for (int i = 0; i < pre_len; i++) send_bit(1'b1, 1'b1, s);
        for (int i = 1; i >= 0; i--) send_bit(st[i], 1'b1, s);
        for (int i = 1; i >= 0; i--) send_bit(op[i], 1'b1, s);
        for (int i = 4; i >= 0; i--) send_bit(phy[i], 1'b1, s);
        for (int i = 4; i >= 0; i--) send_bit(rg[i], 1'b1, s);
        for (int i = 1; i >= 0; i--) send_bit(ta[i], ta_oe, s);
        for (int i = 15; i >= 0; i--) begin
            send_bit(data[i], data_oe, s);
            seen[i] = s;
        end
        // released-line gap so no run of ones spans two frames
        for (int i = 0; i < 3; i++) send_bit(1'b0, 1'b0, s);
        @(negedge clk);
        mgt_clk_r = 1'b0;
    endtask

    task automatic do_write(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
        logic [15:0] seen;
        run_frame(32, 2'b01, 2'b01, phy, rg, 2'b10, 1'b1, d, 1'b1, seen);
    endtask

    task automatic do_read(input logic [4:0] phy, input logic [4:0] rg, output logic [15:0] v);
        run_frame(32, 2'b01, 2'b10, phy, rg, 2'b00, 1'b0, 16'h0000, 1'b0, v);
    endtask

    task automatic park_high();
        logic [15:0] v;
        do_read(5'd0, 5'd31, v);
        check16("R11 park read", {15'd0, mgt_din_o}, 16'h0001);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check16("R1 din after reset", {15'd0, mgt_din_o}, 16'h0000);
        do_read(5'd0, 5'd2, v);  check16("R1 reg2 id", v, 16'h0022);
        do_read(5'd0, 5'd3, v);  check16("R1 reg3 id", v, 16'h161A);
        do_read(5'd0, 5'd0, v);  check16("R1 reg0 zero", v, 16'h0000);
        do_read(5'd0, 5'd31, v); check16("R1 reg31 zero", v, 16'h0000);
    endtask

    task automatic t_write_read();
        logic [15:0] v;
        do_write(5'd1, 5'd5, 16'hA5C3);
        do_read(5'd1, 5'd5, v);
        check16("R8 R4 reg5 readback", v, 16'hA5C3);
        do_write(5'd1, 5'd17, 16'h3C5A);
        do_read(5'd1, 5'd17, v);
        check16("R8 reg17 readback", v, 16'h3C5A);
        do_read(5'd1, 5'd5, v);
        check16("R4 reg5 untouched by reg17 write", v, 16'hA5C3);
    endtask

    task automatic t_phy_any();
        logic [15:0] v;
        do_write(5'h1F, 5'd31, 16'h8001);
        do_read(5'h00, 5'd31, v);
        check16("R9 other phy address", v, 16'h8001);
        do_read(5'h0A, 5'd3, v);
        check16("R9 id via phy 0x0A", v, 16'h161A);
    endtask

    task automatic t_enable_gate();
        logic [15:0] v;
        logic [15:0] seen;
        do_write(5'd0, 5'd7, 16'h1234);
        run_frame(32, 2'b01, 2'b01, 5'd0, 5'd7, 2'b10, 1'b1, 16'hFFFF, 1'b0, seen);
        do_read(5'd0, 5'd7, v);
        check16("R2 data with enable low", v, 16'h0000);
    endtask

    task automatic t_bad_write();
        logic [15:0] v;
        logic [15:0] seen;
        run_frame(32, 2'b01, 2'b01, 5'd0, 5'd5, 2'b11, 1'b1, 16'h0F0F, 1'b1, seen);
        do_read(5'd0, 5'd5, v); check16("R5 turnaround 11 rejected", v, 16'hA5C3);
        run_frame(32, 2'b01, 2'b01, 5'd0, 5'd5, 2'b00, 1'b1, 16'h0F0F, 1'b1, seen);
        do_read(5'd0, 5'd5, v); check16("R5 turnaround 00 rejected", v, 16'hA5C3);
        run_frame(32, 2'b00, 2'b01, 5'd0, 5'd5, 2'b10, 1'b1, 16'h0F0F, 1'b1, seen);
        do_read(5'd0, 5'd5, v); check16("R7 start 00 rejected", v, 16'hA5C3);
        run_frame(32, 2'b01, 2'b11, 5'd0, 5'd5, 2'b10, 1'b1, 16'h0F0F, 1'b1, seen);
        do_read(5'd0, 5'd5, v); check16("R7 opcode 11 rejected", v, 16'hA5C3);
    endtask

    task automatic t_bad_read();
        logic [15:0] seen;
        park_high();
        run_frame(32, 2'b01, 2'b10, 5'd0, 5'd3, 2'b01, 1'b1, 16'h0000, 1'b0, seen);
        check16("R6 read with turnaround bit0 high", seen, 16'hFFFF);
        run_frame(32, 2'b01, 2'b00, 5'd0, 5'd3, 2'b00, 1'b0, 16'h0000, 1'b0, seen);
        check16("R7 opcode 00 no response", seen, 16'hFFFF);
        run_frame(32, 2'b01, 2'b10, 5'd0, 5'd3, 2'b10, 1'b1, 16'h0000, 1'b0, seen);
        check16("R6 read with turnaround 10", seen, 16'h161A);
    endtask

    task automatic t_id_protect();
        logic [15:0] v;
        do_write(5'd0, 5'd2, 16'hFFFF);
        do_write(5'd0, 5'd3, 16'h0000);
        do_read(5'd0, 5'd2, v); check16("R10 reg2 write ignored", v, 16'h0022);
        do_read(5'd0, 5'd3, v); check16("R10 reg3 write ignored", v, 16'h161A);
    endtask

    task automatic t_short_preamble();
        logic [15:0] seen;
        logic [15:0] v;
        park_high();
        run_frame(31, 2'b01, 2'b10, 5'd0, 5'd3, 2'b00, 1'b0, 16'h0000, 1'b0, seen);
        check16("R3 31-one preamble read ignored", seen, 16'hFFFF);
        run_frame(31, 2'b01, 2'b01, 5'd0, 5'd5, 2'b10, 1'b1, 16'h7777, 1'b1, seen);
        do_read(5'd0, 5'd5, v);
        check16("R3 31-one preamble write ignored", v, 16'hA5C3);
    endtask

    task automatic t_hold();
        park_high();
        repeat (60) @(negedge clk);
        check16("R11 din held while idle", {15'd0, mgt_din_o}, 16'h0001);
        mgt_clk_r = 1'b1;
        repeat (20) @(negedge clk);
        mgt_clk_r = 1'b0;
        repeat (20) @(negedge clk);
        check16("R11 din held over stray edge", {15'd0, mgt_din_o}, 16'h0001);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_write_read();
        t_phy_any();
        t_enable_gate();
        t_bad_write();
        t_bad_read();
        t_id_protect();
        t_short_preamble();
        t_hold();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule